// File: doc/BRIEF.md
# Region Access Guard

This block sits beside the slave side of one or more bus ports and judges every transfer against a table of programmable address regions. Each region carries a 32-byte-aligned inclusive lower and upper bound, a permission word and a valid flag. During the address phase, all regions are compared in parallel with the request. The verdict is purely combinational. A permitted transfer is forwarded to the slave. A refused one is answered with an error response and is never forwarded.

The processor, master 0, has separate read, write and execute permissions for supervisor mode and for user mode. Every other master has only read and write permissions. When regions overlap, any single region that contains the address and grants the access is enough. Until software sets the global enable, the guard forwards everything.

Each port keeps a record of its most recent refused transfer. The record holds the byte address, the attributes and a map of the regions that contained the address but refused it. A small write-only configuration port programs the regions. Writes to a region's bounds or to its primary permission word drop the region's valid flag. A separate alias space rewrites only the permission word.

Top module: `bus_region_guard`

## Requirements
- R1: After reset the guard is disabled: every request is forwarded, no error response is given and no fault is recorded.
- R2: A region contains an address when its valid flag is set and lower <= addr[31:5] <= upper, with both bounds inclusive. The bounds are taken from write data bits 31:5.
- R3: For master 0 the permission word bits are: user read at bit 0, user write at bit 1, user execute at bit 2, supervisor read at bit 3, supervisor write at bit 4 and supervisor execute at bit 5. An instruction fetch needs the execute bit of the current mode.
- R4: For master m >= 1 the read permission is bit 6+2(m-1) and the write permission is bit 7+2(m-1). An instruction fetch from such a master counts as a read.
- R5: With overlapping regions, the access is permitted when at least one containing region grants it.
- R6: When enabled, an access that falls in no valid region is refused.
- R7: In the same cycle as the request, a permitted request raises slave_req with err_resp low, and a refused one raises err_resp with slave_req low. An idle port raises neither.
- R8: On the clock edge after a refusal, the port's record takes the byte address, master, write, supervisor and instruction flags. It also takes a map with bit r set when region r was valid and contained the address but refused the access. err_seen rises and stays set.
- R9: Configuration space 0 addresses region words. A write to word 0 (lower bound), word 1 (upper bound) or word 2 (permission) clears that region's valid flag. A write to word 3 loads the valid flag from data bit 0.
- R10: A write in configuration space 1 replaces the region's permission word and leaves its bounds and valid flag unchanged.
- R11: A write in configuration space 2 loads the global enable from data bit 0. Clearing it makes the guard forward everything again.
- R12: Ports are judged and recorded independently: a fault on one port leaves the other port's record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_space | input | 2 | 0 region words, 1 permission alias, 2 global control |
| cfg_region | input | RIDX_W | Region index |
| cfg_word | input | 2 | Word within a region (space 0) |
| cfg_wdata | input | 32 | Configuration write data |
| bus_valid | input | NUM_PORTS | Request present, per port |
| bus_addr | input | NUM_PORTS x 32 | Byte address, per port |
| bus_master | input | NUM_PORTS x MASTER_W | Requesting master index |
| bus_write | input | NUM_PORTS | 1 write, 0 read |
| bus_sup | input | NUM_PORTS | 1 supervisor, 0 user |
| bus_instr | input | NUM_PORTS | 1 instruction fetch, 0 data |
| slave_req | output | NUM_PORTS | Forward request to the slave |
| err_resp | output | NUM_PORTS | Protection error response |
| err_addr | output | NUM_PORTS x 32 | Recorded fault address |
| err_master | output | NUM_PORTS x MASTER_W | Recorded master |
| err_write | output | NUM_PORTS | Recorded write flag |
| err_sup | output | NUM_PORTS | Recorded supervisor flag |
| err_instr | output | NUM_PORTS | Recorded instruction flag |
| err_map | output | NUM_PORTS x NUM_REGIONS | Recorded refusing-region map |
| err_seen | output | NUM_PORTS | A fault has been recorded since reset |

## Verification
The assertions watch every cycle for the properties of the verdict's outcome. They check that an idle port stays quiet and that a live request gets exactly one outcome. They check that the disabled guard forwards, and that each refusal is recorded on the next edge with a sticky seen flag and the record otherwise held. Which outcome is correct depends on the programmed table, so only the bench's scenarios show it. These cover the inclusive bounds, the mode-specific and per-master permission bits, OR-combining of overlapping regions, the valid-flag side effects of each configuration word against the alias space, and the contents of the refusing-region map.

// File: rtl/bus_guard_pkg.sv
package bus_guard_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned GRAN_W = 5;
    localparam int unsigned BND_W  = ADDR_W - GRAN_W;

    typedef struct packed {
        logic [BND_W-1:0] lo;
        logic [BND_W-1:0] hi;
        logic [31:0]      acc;
        logic             vld;
    } rgn_desc_t;

    typedef enum logic [1:0] {
        SP_DESC  = 2'd0,
        SP_ALIAS = 2'd1,
        SP_CTRL  = 2'd2
    } cfg_space_e;

    typedef enum logic [1:0] {
        W_LO  = 2'd0,
        W_HI  = 2'd1,
        W_ACC = 2'd2,
        W_VLD = 2'd3
    } desc_word_e;

    // Permission lookup: master 0 uses mode-split RWX, others use RW pairs.
    function automatic logic perm_ok(input logic [31:0] acc, input int unsigned master,
                                     input int unsigned num_masters,
                                     input logic wr, input logic sup, input logic instr);
        int unsigned base;
        logic [31:0] sh;
        if (master >= num_masters) return 1'b0;
        if (master == 0) begin
            base = sup ? 3 : 0;
            sh   = acc >> base;
            return instr ? sh[2] : (wr ? sh[1] : sh[0]);
        end
        base = 6 + 2 * (master - 1);
        if (base + 1 > 31) return 1'b0;
        sh = acc >> base;
        return wr ? sh[1] : sh[0];
    endfunction

endpackage

// File: rtl/bg_desc_regs.sv
module bg_desc_regs
    import bus_guard_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16,
    localparam int unsigned RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [1:0]                  cfg_space,
    input  logic [RIDX_W-1:0]           cfg_region,
    input  logic [1:0]                  cfg_word,
    input  logic [31:0]                 cfg_wdata,
    output rgn_desc_t [NUM_REGIONS-1:0] desc_o,
    output logic                        enable_o
);

    typedef struct packed {
        rgn_desc_t [NUM_REGIONS-1:0] rgn;
        logic                        en;
    } state_t;

    state_t s_d, s_q;
    logic   idx_ok;

    assign idx_ok = int'(cfg_region) < NUM_REGIONS;

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            case (cfg_space)
                SP_DESC: if (idx_ok) begin
                    case (cfg_word)
                        W_LO: begin
                            s_d.rgn[cfg_region].lo  = cfg_wdata[ADDR_W-1:GRAN_W];
                            s_d.rgn[cfg_region].vld = 1'b0;
                        end
                        W_HI: begin
                            s_d.rgn[cfg_region].hi  = cfg_wdata[ADDR_W-1:GRAN_W];
                            s_d.rgn[cfg_region].vld = 1'b0;
                        end
                        W_ACC: begin
                            s_d.rgn[cfg_region].acc = cfg_wdata;
                            s_d.rgn[cfg_region].vld = 1'b0;
                        end
                        W_VLD: s_d.rgn[cfg_region].vld = cfg_wdata[0];
                    endcase
                end
                SP_ALIAS: if (idx_ok) s_d.rgn[cfg_region].acc = cfg_wdata;
                SP_CTRL:  s_d.en = cfg_wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign desc_o   = s_q.rgn;
    assign enable_o = s_q.en;

endmodule

// File: rtl/bg_port_check.sv
module bg_port_check
    import bus_guard_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16,
    parameter int unsigned NUM_MASTERS = 4,
    parameter int unsigned MASTER_W    = 2
) (
    input  rgn_desc_t [NUM_REGIONS-1:0] desc_i,
    input  logic                        enable_i,
    input  logic                        req_valid,
    input  logic [BND_W-1:0]            blk,
    input  logic [MASTER_W-1:0]         master,
    input  logic                        wr,
    input  logic                        sup,
    input  logic                        instr,
    output logic                        pass_o,
    output logic                        fault_o,
    output logic [NUM_REGIONS-1:0]      deny_map_o
);

    logic [NUM_REGIONS-1:0] hit, grant;
    logic                   allow;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
        assign hit[r]   = desc_i[r].vld && (blk >= desc_i[r].lo) && (blk <= desc_i[r].hi);
        assign grant[r] = hit[r] && perm_ok(desc_i[r].acc, int'(master), NUM_MASTERS, wr, sup, instr);
        assign deny_map_o[r] = hit[r] && !grant[r];
    end

    assign allow   = !enable_i || (|grant);
    assign pass_o  = req_valid && allow;
    assign fault_o = req_valid && !allow;

endmodule

// File: rtl/bg_fault_log.sv
module bg_fault_log
    import bus_guard_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16,
    parameter int unsigned MASTER_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fault_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [MASTER_W-1:0]    master_i,
    input  logic                   wr_i,
    input  logic                   sup_i,
    input  logic                   instr_i,
    input  logic [NUM_REGIONS-1:0] map_i,
    output logic [ADDR_W-1:0]      addr_o,
    output logic [MASTER_W-1:0]    master_o,
    output logic                   wr_o,
    output logic                   sup_o,
    output logic                   instr_o,
    output logic [NUM_REGIONS-1:0] map_o,
    output logic                   seen_o
);

    typedef struct packed {
        logic [ADDR_W-1:0]      addr;
        logic [MASTER_W-1:0]    master;
        logic                   wr;
        logic                   sup;
        logic                   instr;
        logic [NUM_REGIONS-1:0] map;
        logic                   seen;
    } log_t;

    log_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (fault_i) begin
            l_d.addr   = addr_i;
            l_d.master = master_i;
            l_d.wr     = wr_i;
            l_d.sup    = sup_i;
            l_d.instr  = instr_i;
            l_d.map    = map_i;
            l_d.seen   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign addr_o   = l_q.addr;
    assign master_o = l_q.master;
    assign wr_o     = l_q.wr;
    assign sup_o    = l_q.sup;
    assign instr_o  = l_q.instr;
    assign map_o    = l_q.map;
    assign seen_o   = l_q.seen;

endmodule

// File: rtl/bus_region_guard.sv
module bus_region_guard
    import bus_guard_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16,
    parameter int unsigned NUM_PORTS   = 2,
    parameter int unsigned NUM_MASTERS = 4,
    localparam int unsigned MASTER_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
    localparam int unsigned RIDX_W   = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic [1:0]                            cfg_space,
    input  logic [RIDX_W-1:0]                     cfg_region,
    input  logic [1:0]                            cfg_word,
    input  logic [31:0]                           cfg_wdata,
    input  logic [NUM_PORTS-1:0]                  bus_valid,
    input  logic [NUM_PORTS-1:0][31:0]            bus_addr,
    input  logic [NUM_PORTS-1:0][MASTER_W-1:0]    bus_master,
    input  logic [NUM_PORTS-1:0]                  bus_write,
    input  logic [NUM_PORTS-1:0]                  bus_sup,
    input  logic [NUM_PORTS-1:0]                  bus_instr,
    output logic [NUM_PORTS-1:0]                  slave_req,
    output logic [NUM_PORTS-1:0]                  err_resp,
    output logic [NUM_PORTS-1:0][31:0]            err_addr,
    output logic [NUM_PORTS-1:0][MASTER_W-1:0]    err_master,
    output logic [NUM_PORTS-1:0]                  err_write,
    output logic [NUM_PORTS-1:0]                  err_sup,
    output logic [NUM_PORTS-1:0]                  err_instr,
    output logic [NUM_PORTS-1:0][NUM_REGIONS-1:0] err_map,
    output logic [NUM_PORTS-1:0]                  err_seen
);

    rgn_desc_t [NUM_REGIONS-1:0] desc;
    logic                        guard_en;

    bg_desc_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_space  (cfg_space),
        .cfg_region (cfg_region),
        .cfg_word   (cfg_word),
        .cfg_wdata  (cfg_wdata),
        .desc_o     (desc),
        .enable_o   (guard_en)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic                   fault;
        logic [NUM_REGIONS-1:0] deny_map;

        bg_port_check #(
            .NUM_REGIONS (NUM_REGIONS),
            .NUM_MASTERS (NUM_MASTERS),
            .MASTER_W    (MASTER_W)
        ) u_check (
            .desc_i     (desc),
            .enable_i   (guard_en),
            .req_valid  (bus_valid[p]),
            .blk        (bus_addr[p][ADDR_W-1:GRAN_W]),
            .master     (bus_master[p]),
            .wr         (bus_write[p]),
            .sup        (bus_sup[p]),
            .instr      (bus_instr[p]),
            .pass_o     (slave_req[p]),
            .fault_o    (fault),
            .deny_map_o (deny_map)
        );

        assign err_resp[p] = fault;

        bg_fault_log #(
            .NUM_REGIONS (NUM_REGIONS),
            .MASTER_W    (MASTER_W)
        ) u_log (
            .clk      (clk),
            .rst_n    (rst_n),
            .fault_i  (fault),
            .addr_i   (bus_addr[p]),
            .master_i (bus_master[p]),
            .wr_i     (bus_write[p]),
            .sup_i    (bus_sup[p]),
            .instr_i  (bus_instr[p]),
            .map_i    (deny_map),
            .addr_o   (err_addr[p]),
            .master_o (err_master[p]),
            .wr_o     (err_write[p]),
            .sup_o    (err_sup[p]),
            .instr_o  (err_instr[p]),
            .map_o    (err_map[p]),
            .seen_o   (err_seen[p])
        );
    end

endmodule

// File: rtl/bus_region_guard_chk.sv
module bus_region_guard_chk #(
    parameter int unsigned NUM_PORTS = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enable,
    input logic [NUM_PORTS-1:0]       bus_valid,
    input logic [NUM_PORTS-1:0][31:0] bus_addr,
    input logic [NUM_PORTS-1:0]       slave_req,
    input logic [NUM_PORTS-1:0]       err_resp,
    input logic [NUM_PORTS-1:0][31:0] err_addr,
    input logic [NUM_PORTS-1:0]       err_seen
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_valid[p] |-> (!slave_req[p] && !err_resp[p])); // R7
        AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
            bus_valid[p] |-> (slave_req[p] != err_resp[p])); // R7
        AST_OFF_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable && bus_valid[p]) |-> slave_req[p]); // R1
        AST_FAULT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
            err_resp[p] |=> (err_seen[p] && err_addr[p] == $past(bus_addr[p]))); // R8
        AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !err_resp[p] |=> $stable(err_addr[p])); // R8
        AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            err_seen[p] |=> err_seen[p]); // R8
    end

endmodule

bind bus_region_guard bus_region_guard_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (guard_en),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .slave_req (slave_req),
    .err_resp  (err_resp),
    .err_addr  (err_addr),
    .err_seen  (err_seen)
);

// File: tb/bus_region_guard_test.sv
module bus_region_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;
    localparam int NP = 2;
    localparam int MW = 2;
    localparam int RW = 4;

    logic                   clk, rst_n;
    logic                   cfg_we;
    logic [1:0]             cfg_space;
    logic [RW-1:0]          cfg_region;
    logic [1:0]             cfg_word;
    logic [31:0]            cfg_wdata;
    logic [NP-1:0]          bus_valid, bus_write, bus_sup, bus_instr;
    logic [NP-1:0][31:0]    bus_addr;
    logic [NP-1:0][MW-1:0]  bus_master;
    logic [NP-1:0]          slave_req, err_resp, err_write, err_sup, err_instr, err_seen;
    logic [NP-1:0][31:0]    err_addr;
    logic [NP-1:0][MW-1:0]  err_master;
    logic [NP-1:0][NR-1:0]  err_map;

    bus_region_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_space(cfg_space),
        .cfg_region(cfg_region), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_master(bus_master),
        .bus_write(bus_write), .bus_sup(bus_sup), .bus_instr(bus_instr),
        .slave_req(slave_req), .err_resp(err_resp), .err_addr(err_addr),
        .err_master(err_master), .err_write(err_write), .err_sup(err_sup),
        .err_instr(err_instr), .err_map(err_map), .err_seen(err_seen)
    );

    typedef struct {
        int    port;
        logic  req;
        logic  err;
        string tag;
    } exp_t;

    exp_t sbq[$];
    event sample_ev;
    int   compared = 0;
    int   mismatched = 0;
    bit   done = 0;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops expected outcomes and compares against the ports.
    initial begin
        exp_t e;
        forever begin
            @(sample_ev);
            while (sbq.size() > 0) begin
                e = sbq.pop_front();
                compared++;
                if (slave_req[e.port] !== e.req || err_resp[e.port] !== e.err) begin
                    mismatched++;
                    $display("FAIL %s: port%0d req/err = %b/%b, expected %b/%b",
                             e.tag, e.port, slave_req[e.port], err_resp[e.port], e.req, e.err);
                end
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h, expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(logic [1:0] space, int region, logic [1:0] word, logic [31:0] data);
        @(negedge clk);
        cfg_space  = space;
        cfg_region = RW'(region);
        cfg_word   = word;
        cfg_wdata  = data;
        cfg_we     = 1'b1;
        @(negedge clk);
        cfg_we     = 1'b0;
    endtask

    task automatic set_region(int r, logic [31:0] lo, logic [31:0] hi, logic [31:0] acc);
        cfg(2'd0, r, 2'd0, lo);
        cfg(2'd0, r, 2'd1, hi);
        cfg(2'd0, r, 2'd2, acc);
        cfg(2'd0, r, 2'd3, 32'd1);
    endtask

    // Driver: one request for exactly one rising edge; expected outcome queued.
    task automatic access(int port, logic [31:0] addr, int master, logic wr, logic sup,
                          logic instr, logic ok, string tag);
        @(negedge clk);
        bus_valid         = '0;
        bus_addr[port]    = addr;
        bus_master[port]  = MW'(master);
        bus_write[port]   = wr;
        bus_sup[port]     = sup;
        bus_instr[port]   = instr;
        bus_valid[port]   = 1'b1;
        #1;
        sbq.push_back('{port, ok, !ok, tag});
        -> sample_ev;
        @(negedge clk);
        bus_valid = '0;
    endtask

    task automatic check_log(int port, logic [31:0] addr, int master, logic wr, logic sup,
                             logic instr, logic [NR-1:0] map, string tag);
        chk({tag, " addr"}, 64'(err_addr[port]), 64'(addr));
        chk({tag, " attrs"}, 64'({err_master[port], err_write[port], err_sup[port],
                                  err_instr[port], err_seen[port]}),
            64'({MW'(master), wr, sup, instr, 1'b1}));
        chk({tag, " map"}, 64'(err_map[port]), 64'(map));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_space = '0; cfg_region = '0; cfg_word = '0;
        cfg_wdata = '0; bus_valid = '0; bus_addr = '0; bus_master = '0;
        bus_write = '0; bus_sup = '0; bus_instr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset outputs", 64'({slave_req, err_resp, err_seen}), 64'(0));

        // R1: disabled guard forwards and records nothing
        access(0, 32'h1000, 1, 1'b1, 1'b0, 1'b0, 1'b1, "R1 disabled forward");
        chk("R1 no record while disabled", 64'(err_seen), 64'(0));

        // R11 enable, R6 no region
        cfg(2'd2, 0, 2'd0, 32'd1);
        access(0, 32'h1000, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 no region");
        check_log(0, 32'h1000, 1, 1'b0, 1'b0, 1'b0, '0, "R8 miss record");

        // R2 bounds, R4 master read-only region 0
        set_region(0, 32'h1000, 32'h1FE0, 32'h40);
        access(0, 32'h1000, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R2 low bound");
        access(0, 32'h1FFF, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R2 high bound");
        access(0, 32'h2000, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 above");
        access(0, 32'h0FFF, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 below");
        access(0, 32'h1800, 1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 write denied");
        check_log(0, 32'h1800, 1, 1'b1, 1'b0, 1'b0, 16'h0001, "R8 denied record");
        chk("R12 port1 untouched", 64'(err_seen[1]), 64'(0));
        access(0, 32'h1800, 1, 1'b0, 1'b0, 1'b1, 1'b1, "R4 fetch as read");

        // R3 processor: supervisor read+execute only
        set_region(1, 32'h4000, 32'h4FE0, 32'h28);
        access(0, 32'h4100, 0, 1'b0, 1'b1, 1'b0, 1'b1, "R3 sup read");
        access(0, 32'h4100, 0, 1'b0, 1'b1, 1'b1, 1'b1, "R3 sup exec");
        access(0, 32'h4100, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 user read");
        check_log(0, 32'h4100, 0, 1'b0, 1'b0, 1'b0, 16'h0002, "R8 user record");
        access(0, 32'h4100, 0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 sup write");

        // R5 overlap: region 2 grants master 1 write
        set_region(2, 32'h1000, 32'h1FE0, 32'h80);
        access(0, 32'h1800, 1, 1'b1, 1'b0, 1'b0, 1'b1, "R5 overlap write");
        access(0, 32'h1800, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R5 overlap read");
        access(0, 32'h1800, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R4 master2 no bits");
        check_log(0, 32'h1800, 2, 1'b0, 1'b0, 1'b0, 16'h0005, "R8 two-region map");

        // R9 bound write clears valid, word 3 restores
        cfg(2'd0, 0, 2'd0, 32'h1000);
        access(0, 32'h1000, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 lo write invalidates");
        cfg(2'd0, 0, 2'd3, 32'd1);
        access(0, 32'h1000, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R9 valid restored");

        // R10 alias keeps valid
        cfg(2'd1, 0, 2'd0, 32'h0);
        access(0, 32'h1000, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 alias cleared perms");
        cfg(2'd1, 0, 2'd0, 32'h40);
        access(0, 32'h1000, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R10 alias kept valid");
        cfg(2'd0, 0, 2'd2, 32'h40);
        access(0, 32'h1000, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 perm word invalidates");
        cfg(2'd0, 0, 2'd3, 32'd1);

        // R12 ports independent
        access(1, 32'h1000, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R12 port1 allowed");
        access(1, 32'h9000, 3, 1'b1, 1'b1, 1'b0, 1'b0, "R12 port1 fault");
        check_log(1, 32'h9000, 3, 1'b1, 1'b1, 1'b0, '0, "R12 port1 record");
        chk("R12 port0 record kept", 64'(err_addr[0]), 64'(32'h1000));

        // R11 disable again
        cfg(2'd2, 0, 2'd0, 32'd0);
        access(0, 32'h9000, 2, 1'b1, 1'b0, 1'b0, 1'b1, "R11 disabled forward");
        chk("R11 no record when disabled", 64'(err_addr[0]), 64'(32'h1000));

        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule